// File: doc/BRIEF.md
# DMA Controller Host Register File

This block is the processor-facing register file of a four-channel DMA controller. A host reaches it over an 8-bit data bus with a 4-bit register offset and separate read and write strobes. Each channel owns two 16-bit values, a base address and a transfer count. Both travel through single 8-bit ports, and one byte pointer shared by all channels chooses which half an access reaches.

The remaining offsets hold the control state. They set or clear masks one channel at a time or all at once. They load a per-channel mode, hold a command byte and raise or drop software requests. Other offsets reset the byte pointer or perform a master clear. A status read reports latched terminal-count events and pending requests, and the terminal-count bits clear as they are read. The transfer engine receives every channel's mask, mode, base address and count as registered outputs, and it returns terminal-count pulses and hardware request levels.

Top module: `dma_host_regs`

## Requirements
- R1: A synchronous reset sets all four mask bits to 1. It sets the address, count, mode, command, software request and terminal-count state to zero, clears the byte pointer and sets `rdata` to 0x00.
- R2: The address port of channel n is at offset 2n and its count port is at offset 2n+1. A write loads the low byte when the byte pointer is 0 and the high byte when it is 1. A write to any other offset leaves every address and count unchanged.
- R3: The byte pointer is shared by all eight address and count ports. It toggles on every read or write to any of them. A read returns the low byte of the stored value when the pointer is 0 and the high byte when it is 1.
- R4: A write to offset 0xC clears the byte pointer whatever the data. The next port access then reaches a low byte.
- R5: A write to offset 0xA selects a channel with data bits [1:0]. Data bit 2 set masks that channel and bit 2 clear unmasks it. The other mask bits do not change.
- R6: A write to offset 0xE clears all four mask bits. A write to offset 0xF copies data bits [3:0] into the mask bits, with bit n belonging to channel n.
- R7: A write to offset 0xB selects a channel with data bits [1:0] and stores data bits [7:2] as that channel's 6-bit mode, with data bit k landing in mode bit k-2. With this layout, 0x44 gives mode 0x11 (I/O to memory, single, increment), 0x48 gives 0x12 (memory to I/O) and 0xC0 gives 0x30 (cascade). Data bit 4 (mode bit 2) is the autoinit flag.
- R8: A write to offset 0x8 loads the command byte. A read of offset 0x8 returns pending requests in bits [7:4] and terminal-count flags in bits [3:0], then clears those flags. A terminal-count pulse that arrives in the same cycle as the read is kept and shows on the next read.
- R9: A write to offset 0x9 selects a channel with data bits [1:0] and sets (bit 2 = 1) or clears (bit 2 = 0) its software request. Status bit 4+n is the OR of that software request and hardware request n.
- R10: A write to offset 0xD is a master clear. It sets all masks and clears the byte pointer, the command byte, the software requests and the terminal-count flags. It leaves every address, count and mode unchanged.
- R11: Read data is registered. `rdata` takes the addressed value on the clock edge that samples `rd_en` and holds it until the next read. A read of offset 0xD returns 0x00. When `wr_en` and `rd_en` are both high, the read is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| reg_off | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tc_in | input | 4 | Terminal-count pulses from the transfer engine, one per channel |
| req_in | input | 4 | Hardware request levels, one per channel |
| mask_o | output | 4 | Channel mask bits, bit n for channel n |
| mode_o | output | 24 | Per-channel 6-bit mode, channel n at bits [6n+5:6n] |
| base_addr_o | output | 64 | Per-channel base address, channel n at bits [16n+15:16n] |
| base_cnt_o | output | 64 | Per-channel base count, channel n at bits [16n+15:16n] |
| cmd_o | output | 8 | Command byte |
| sw_req_o | output | 4 | Software request bits |

## Verification
The address and count ports are driven with two kinds of pattern. A distinct scrambled value per channel and port shows up any crossed channel or swapped port. A walking one across all sixteen bit positions shows up any crossed byte lanes. Interleaved accesses to different channels without a pointer reset confirm that a single pointer is shared. The sweeps cover all 16 values of the all-mask write and all eight single-mask operations. The mode sweep writes all 64 modes on every channel, which tells the channel select apart from the stored field. The status read is tried with a terminal-count pulse arriving in the same cycle, to tell clear-on-read ordering from set priority.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;
  localparam int OFF_W = 4;

  localparam logic [OFF_W-1:0] OFF_CMD     = 4'h8;
  localparam logic [OFF_W-1:0] OFF_REQ     = 4'h9;
  localparam logic [OFF_W-1:0] OFF_SMASK   = 4'hA;
  localparam logic [OFF_W-1:0] OFF_MODE    = 4'hB;
  localparam logic [OFF_W-1:0] OFF_CLRPTR  = 4'hC;
  localparam logic [OFF_W-1:0] OFF_MCLR    = 4'hD;
  localparam logic [OFF_W-1:0] OFF_CLRMASK = 4'hE;
  localparam logic [OFF_W-1:0] OFF_AMASK   = 4'hF;

  // decoded control-register write strobes
  typedef struct packed {
    logic cmd;
    logic req;
    logic smask;
    logic clrmask;
    logic amask;
    logic mclr;
  } ctl_wr_t;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst,
  input  logic toggle,
  input  logic clear,
  output logic ptr
);
  always_ff @(posedge clk) begin
    if (rst || clear) ptr <= 1'b0;
    else if (toggle)  ptr <= ~ptr;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int DW   = 8,
  parameter int CH_W = 2,
  localparam int RW     = 2 * DW,
  localparam int MODE_W = DW - CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              wr_mode,
  input  logic              hi_sel,
  input  logic [DW-1:0]     wdata,
  output logic [RW-1:0]     base_addr,
  output logic [RW-1:0]     base_cnt,
  output logic [MODE_W-1:0] mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      mode      <= '0;
    end else begin
      if (wr_addr) begin
        if (hi_sel) base_addr[RW-1:DW] <= wdata;
        else        base_addr[DW-1:0]  <= wdata;
      end
      if (wr_cnt) begin
        if (hi_sel) base_cnt[RW-1:DW] <= wdata;
        else        base_cnt[DW-1:0]  <= wdata;
      end
      if (wr_mode) mode <= wdata[DW-1:CH_W];
    end
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_reg_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_wr_t          wr_sel,
  input  logic             rd_status,
  input  logic [DW-1:0]    wdata,
  input  logic [NCH-1:0]   tc_in,
  input  logic [NCH-1:0]   req_in,
  output logic [DW-1:0]    cmd_o,
  output logic [NCH-1:0]   mask_o,
  output logic [NCH-1:0]   sw_req_o,
  output logic [2*NCH-1:0] status_o
);
  logic [NCH-1:0]  tc_q;
  logic [CH_W-1:0] wch;
  logic            wflag;

  assign wch   = wdata[CH_W-1:0];
  assign wflag = wdata[CH_W];

  always_ff @(posedge clk) begin
    if (rst || wr_sel.mclr) begin
      cmd_o    <= '0;
      mask_o   <= '1;
      sw_req_o <= '0;
      tc_q     <= '0;
    end else begin
      if (wr_sel.cmd)     cmd_o <= wdata;
      if (wr_sel.smask)   mask_o[wch] <= wflag;
      if (wr_sel.clrmask) mask_o <= '0;
      if (wr_sel.amask)   mask_o <= wdata[NCH-1:0];
      if (wr_sel.req)     sw_req_o[wch] <= wflag;
      // a new event outranks the clear from a status read
      tc_q <= (rd_status ? '0 : tc_q) | tc_in;
    end
  end

  assign status_o = {sw_req_o | req_in, tc_q};
endmodule

// File: rtl/dma_host_regs.sv
module dma_host_regs
  import dma_reg_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CH_W   = $clog2(NCH),
  localparam int RW     = 2 * DW,
  localparam int MODE_W = DW - CH_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [OFF_W-1:0]      reg_off,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  input  logic [NCH-1:0]        tc_in,
  input  logic [NCH-1:0]        req_in,
  output logic [NCH-1:0]        mask_o,
  output logic [NCH*MODE_W-1:0] mode_o,
  output logic [NCH*RW-1:0]     base_addr_o,
  output logic [NCH*RW-1:0]     base_cnt_o,
  output logic [DW-1:0]         cmd_o,
  output logic [NCH-1:0]        sw_req_o
);
  logic            rd_ok;
  logic            port_hit;
  logic [CH_W-1:0] port_ch;
  logic            is_cnt;
  logic            ptr;
  ctl_wr_t         wr_sel;
  logic [2*NCH-1:0] stat_byte;
  logic [RW-1:0]   addr_arr [NCH];
  logic [RW-1:0]   cnt_arr  [NCH];
  logic [RW-1:0]   port_val;
  logic [DW-1:0]   rd_mux;

  assign rd_ok    = rd_en & ~wr_en;
  assign port_hit = (reg_off < OFF_W'(2 * NCH));
  assign port_ch  = reg_off[CH_W:1];
  assign is_cnt   = reg_off[0];

  assign wr_sel.cmd     = wr_en && (reg_off == OFF_CMD);
  assign wr_sel.req     = wr_en && (reg_off == OFF_REQ);
  assign wr_sel.smask   = wr_en && (reg_off == OFF_SMASK);
  assign wr_sel.clrmask = wr_en && (reg_off == OFF_CLRMASK);
  assign wr_sel.amask   = wr_en && (reg_off == OFF_AMASK);
  assign wr_sel.mclr    = wr_en && (reg_off == OFF_MCLR);

  dma_byte_ptr u_ptr (
    .clk    (clk),
    .rst    (rst),
    .toggle (port_hit & (wr_en | rd_ok)),
    .clear  (wr_en && (reg_off == OFF_CLRPTR || reg_off == OFF_MCLR)),
    .ptr    (ptr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic             sel_port;
    logic [MODE_W-1:0] mode_q;
    assign sel_port = wr_en && port_hit && (port_ch == CH_W'(g));

    dma_chan_regs #(.DW(DW), .CH_W(CH_W)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_addr   (sel_port && !is_cnt),
      .wr_cnt    (sel_port && is_cnt),
      .wr_mode   (wr_en && (reg_off == OFF_MODE) && (wdata[CH_W-1:0] == CH_W'(g))),
      .hi_sel    (ptr),
      .wdata     (wdata),
      .base_addr (addr_arr[g]),
      .base_cnt  (cnt_arr[g]),
      .mode      (mode_q)
    );

    assign base_addr_o[g*RW +: RW]       = addr_arr[g];
    assign base_cnt_o[g*RW +: RW]        = cnt_arr[g];
    assign mode_o[g*MODE_W +: MODE_W]    = mode_q;
  end

  dma_ctrl_regs #(.NCH(NCH), .DW(DW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_sel    (wr_sel),
    .rd_status (rd_ok && (reg_off == OFF_CMD)),
    .wdata     (wdata),
    .tc_in     (tc_in),
    .req_in    (req_in),
    .cmd_o     (cmd_o),
    .mask_o    (mask_o),
    .sw_req_o  (sw_req_o),
    .status_o  (stat_byte)
  );

  always_comb begin
    port_val = is_cnt ? cnt_arr[port_ch] : addr_arr[port_ch];
    if (port_hit)                rd_mux = ptr ? port_val[RW-1:DW] : port_val[DW-1:0];
    else if (reg_off == OFF_CMD) rd_mux = DW'(stat_byte);
    else                         rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_ok) rdata <= rd_mux;
  end
endmodule

// File: rtl/dma_host_regs_chk.sv
module dma_host_regs_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CH_W = $clog2(NCH),
  localparam int RW   = 2 * DW
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [3:0]        reg_off,
  input logic [DW-1:0]     wdata,
  input logic [NCH-1:0]    tc_in,
  input logic [NCH-1:0]    mask_o,
  input logic [NCH*RW-1:0] base_addr_o,
  input logic [NCH*RW-1:0] base_cnt_o,
  input logic              ptr,
  input logic [2*NCH-1:0]  stat_byte
);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && reg_off < 4'(2 * NCH)) |=> ($stable(base_addr_o) && $stable(base_cnt_o)));

  p_ptr_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || rd_en) && reg_off < 4'(2 * NCH)) |=> (ptr != $past(ptr)));

  p_ptr_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_off == 4'hC) |=> !ptr);

  p_single_mask_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_off == 4'hA) |=> (mask_o[$past(wdata[CH_W-1:0])] == $past(wdata[CH_W])));

  p_tc_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && reg_off == 4'h8 && tc_in == '0) |=> (stat_byte[NCH-1:0] == '0));

  p_mclr_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_off == 4'hD) |=> (mask_o == '1 && !ptr && $stable(base_addr_o) && $stable(base_cnt_o)));
endmodule

bind dma_host_regs dma_host_regs_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .reg_off     (reg_off),
  .wdata       (wdata),
  .tc_in       (tc_in),
  .mask_o      (mask_o),
  .base_addr_o (base_addr_o),
  .base_cnt_o  (base_cnt_o),
  .ptr         (ptr),
  .stat_byte   (stat_byte)
);

// File: tb/sim_dma_host_regs.sv
module sim_dma_host_regs;
  localparam int NCH = 4;
  localparam int DW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] reg_off = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] tc_in = '0, req_in = '0;
  logic [3:0] mask_o, sw_req_o;
  logic [23:0] mode_o;
  logic [63:0] base_addr_o, base_cnt_o;
  logic [7:0] cmd_o;

  int checks = 0;
  int fails  = 0;

  logic [15:0] addr_m [4];
  logic [15:0] cnt_m  [4];
  logic [5:0]  mode_m [4];
  logic        ptr_m = 1'b0;
  logic [7:0]  d;

  always #4 clk = ~clk;

  dma_host_regs #(.NCH(NCH), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_off(reg_off),
    .wdata(wdata), .rdata(rdata), .tc_in(tc_in), .req_in(req_in),
    .mask_o(mask_o), .mode_o(mode_o), .base_addr_o(base_addr_o),
    .base_cnt_o(base_cnt_o), .cmd_o(cmd_o), .sw_req_o(sw_req_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model update of a port access, per R2/R3/R4/R10
  task automatic model_access(input logic [3:0] o, input logic is_wr, input logic [7:0] v);
    if (o < 4'h8) begin
      if (is_wr) begin
        if (o[0]) begin
          if (ptr_m) cnt_m[o[2:1]][15:8] = v; else cnt_m[o[2:1]][7:0] = v;
        end else begin
          if (ptr_m) addr_m[o[2:1]][15:8] = v; else addr_m[o[2:1]][7:0] = v;
        end
      end
      ptr_m = ~ptr_m;
    end else if (is_wr && (o == 4'hC || o == 4'hD)) ptr_m = 1'b0;
    if (is_wr && o == 4'hB) mode_m[v[1:0]] = v[7:2];
  endtask

  task automatic wr(input logic [3:0] o, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; reg_off = o; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
    model_access(o, 1'b1, v);
  endtask

  task automatic rd(input logic [3:0] o, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; reg_off = o;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
    model_access(o, 1'b0, 8'h00);
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < 4; c++) begin
      chk(req, 64'(base_addr_o[c*16 +: 16]), 64'(addr_m[c]));
      chk(req, 64'(base_cnt_o[c*16 +: 16]), 64'(cnt_m[c]));
      chk(req, 64'(mode_o[c*6 +: 6]), 64'(mode_m[c]));
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] mk;
    logic [15:0] v;
    for (int c = 0; c < 4; c++) begin addr_m[c] = '0; cnt_m[c] = '0; mode_m[c] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 mask", 64'(mask_o), 64'hF);
    chk("R1 cmd", 64'(cmd_o), 64'h0);
    chk("R1 swreq", 64'(sw_req_o), 64'h0);
    chk("R1 rdata", 64'(rdata), 64'h0);
    check_all("R1 regs");

    // R2 scrambled value per channel and port
    wr(4'hC, 8'h00);
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 2; p++) begin
        v = 16'hA5C3 ^ 16'(c * 16'h1357) ^ (p != 0 ? 16'hFF00 : 16'h0000);
        wr(4'(2 * c + p), v[7:0]);
        wr(4'(2 * c + p), v[15:8]);
      end
    check_all("R2 scrambled");
    // R2 walking one across all bit positions
    for (int k = 0; k < 16; k++) begin
      v = 16'(1) << k;
      wr(4'(2 * (k % 4) + (k / 8)), v[7:0]);
      wr(4'(2 * (k % 4) + (k / 8)), v[15:8]);
      check_all("R2 walking");
    end
    // R2: non-port writes leave ports alone
    wr(4'h8, 8'h3C);
    wr(4'h9, 8'h00);
    check_all("R2 hold");

    // R3 readback low then high
    wr(4'hC, 8'h00);
    for (int c = 0; c < 4; c++) begin
      rd(4'(2 * c), d);     chk("R3 addr lo", 64'(d), 64'(addr_m[c][7:0]));
      rd(4'(2 * c), d);     chk("R3 addr hi", 64'(d), 64'(addr_m[c][15:8]));
      rd(4'(2 * c + 1), d); chk("R3 cnt lo", 64'(d), 64'(cnt_m[c][7:0]));
      rd(4'(2 * c + 1), d); chk("R3 cnt hi", 64'(d), 64'(cnt_m[c][15:8]));
    end
    // R3 shared pointer across channels
    wr(4'hC, 8'h00);
    wr(4'h0, 8'h11);
    wr(4'h3, 8'h22);
    check_all("R3 shared write");
    rd(4'h5, d); chk("R3 shared rd lo", 64'(d), 64'(cnt_m[2][7:0]));
    rd(4'h6, d); chk("R3 shared rd hi", 64'(d), 64'(addr_m[3][15:8]));

    // R4 pointer clear ignores data
    rd(4'h0, d);
    wr(4'hC, 8'hFF);
    wr(4'h0, 8'h77);
    chk("R4 low after clear", 64'(base_addr_o[7:0]), 64'h77);
    check_all("R4 regs");

    // R6 all-mask sweep and clear-all
    for (int m = 0; m < 16; m++) begin
      wr(4'hF, 8'hF0 | 8'(m));
      chk("R6 all mask", 64'(mask_o), 64'(m));
    end
    wr(4'hE, 8'hFF);
    chk("R6 clear masks", 64'(mask_o), 64'h0);

    // R5 single mask, all eight operations
    mk = 4'h0;
    for (int s = 1; s >= 0; s--)
      for (int c = 0; c < 4; c++) begin
        wr(4'hA, {5'b10101, 1'(s), 2'(c)});
        mk[c] = 1'(s);
        chk("R5 single mask", 64'(mask_o), 64'(mk));
      end

    // R7 mode sweep
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 64; m++) begin
        wr(4'hB, {6'(m), 2'(c)});
        chk("R7 mode", 64'(mode_o[c*6 +: 6]), 64'(m));
      end
    check_all("R7 other regs");
    wr(4'hB, 8'h45); chk("R7 io-to-mem", 64'(mode_o[11:6]), 64'h11);
    wr(4'hB, 8'h4A); chk("R7 mem-to-io", 64'(mode_o[17:12]), 64'h12);
    wr(4'hB, 8'hC3); chk("R7 cascade", 64'(mode_o[23:18]), 64'h30);
    wr(4'hB, 8'h54); chk("R7 autoinit", 64'(mode_o[2]), 64'h1);

    // R8 command and status
    wr(4'h8, 8'h5A);
    chk("R8 cmd", 64'(cmd_o), 64'h5A);
    @(negedge clk); tc_in = 4'b0101;
    @(negedge clk); tc_in = 4'b0000;
    req_in = 4'b0010;
    wr(4'h9, 8'h07);
    rd(4'h8, d); chk("R8 status", 64'(d), 64'hA5);
    rd(4'h8, d); chk("R8 tc cleared", 64'(d), 64'hA0);
    @(negedge clk);
    rd_en = 1'b1; reg_off = 4'h8; tc_in = 4'b0010;
    @(negedge clk);
    rd_en = 1'b0; tc_in = 4'b0000; d = rdata;
    chk("R8 same-cycle old", 64'(d), 64'hA0);
    rd(4'h8, d); chk("R8 same-cycle kept", 64'(d), 64'hA2);

    // R9 request set and clear per channel
    req_in = 4'b0000;
    wr(4'h9, 8'h03);
    for (int c = 0; c < 4; c++) begin
      wr(4'h9, {5'b0, 1'b1, 2'(c)});
      chk("R9 set", 64'(sw_req_o), 64'(4'(1) << c));
      rd(4'h8, d); chk("R9 status pend", 64'(d[7:4]), 64'(4'(1) << c));
      wr(4'h9, {5'b11111, 1'b0, 2'(c)});
      chk("R9 clear", 64'(sw_req_o), 64'h0);
    end

    // R10 master clear
    wr(4'hE, 8'h00);
    wr(4'h8, 8'hC3);
    wr(4'h9, 8'h05);
    @(negedge clk); tc_in = 4'b1000;
    @(negedge clk); tc_in = 4'b0000;
    rd(4'h2, d);
    wr(4'hD, 8'hAA);
    chk("R10 masks", 64'(mask_o), 64'hF);
    chk("R10 cmd", 64'(cmd_o), 64'h0);
    chk("R10 swreq", 64'(sw_req_o), 64'h0);
    check_all("R10 kept");
    rd(4'h8, d); chk("R10 status", 64'(d), 64'h00);
    rd(4'h1, d); chk("R10 ptr cleared", 64'(d), 64'(cnt_m[0][7:0]));

    // R11 read register behaviour
    rd(4'h3, d);
    repeat (3) @(negedge clk);
    chk("R11 hold", 64'(rdata), 64'(d));
    rd(4'hD, d); chk("R11 temp", 64'(d), 64'h00);
    rd(4'h2, d);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; reg_off = 4'hF; wdata = 8'h03;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 read ignored", 64'(rdata), 64'(d));
    chk("R11 write taken", 64'(mask_o), 64'h3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule